// File: doc/BRIEF.md
# Rotating Wide Register Bank

This block holds the wide data and key registers of a crypto engine and exposes them only through a 32-bit access port. A wide register is never indexed by word address. Each access moves exactly one word, and the whole register rotates by one word position. A write pushes the new word in at the most significant end and drops the least significant word. A read returns the least significant word and wraps it around to the top. Software therefore moves a value least significant word first. A complete transfer restores the register's original position.

The storage consists of four 128-bit data registers, a key register and a key buffer of 256 bits each. The block offers several views of this storage:
- 256-bit pair views of data registers.
- A 512-bit view of all four data registers.
- A 512-bit view of key and key buffer.
- Byte-reversed views for big-endian hashing data.

Extra ports on the first two data registers support the following:
- XOR accumulation.
- Byte access gathered into words.
- Direct byte access to the top word, without rotation.

A mode bit selects whether the key registers act as 128 or 256 bits on their own. A low-power request clears everything except the key buffer.

Top module: `wide_reg_bank`

## Requirements
- R1: A word read (op 0, views 0..11) returns the least significant word of the view on rdata and rotates the view right by one word. N reads in a row return the words LSW first and leave the view unchanged. N is 4 for views 0..3, 8 for views 6, 7 and 10, and 16 for views 8, 9 and 11.
- R2: A word write (op 0) shifts the view right by one word and places wdata in the top word, so N writes leave the first written word at the least significant position.
- R3: Stopping a read sequence after k < N reads leaves the view rotated right by k words.
- R4: The XOR port (op 1) acts on data register 0 (view 0). A write places (wdata XOR current least significant word) at the top while shifting, and a read behaves as an op 0 read of view 0.
- R5: Byte ports collect bytes in order, LSB first. Op 2 targets register 0, op 4 targets register 1, and op 3 is the XOR variant on register 0. Each fourth write performs one word shift with the gathered word. A 2-bit group counter advances on each byte access and wraps to 0 after four. Reset and low-power clear the counter. Word and direct accesses leave the counter unchanged.
- R6: A byte read at group position 0 returns byte 0 of the least significant word, latches that word and rotates the register by one word. Reads at positions 1..3 return bytes 1..3 of the latched word without rotating.
- R7: Used alone (view 4 key, view 5 key buffer), a key register spans 8 words when wideKey is 1 and 4 words when it is 0. In the narrow case its upper 128 bits are untouched. Inside view 9 (key buffer high, key low) both are always 256 bits.
- R8: Views share storage. View 6 is {reg1, reg0}, view 7 is {reg3, reg2}, view 8 is {view 7, view 6} and view 9 is {key buffer, key}. A write through any view is visible through every other view of the same bits.
- R9: View 10 (over view 6) and view 11 (over view 9) reverse the byte order within every 32-bit word on both read and write, and rotate like their base view.
- R10: A cycle with lowPower high clears all data registers, the key, the byte buffer and the group counter, and ignores any access in that cycle. The key buffer keeps its value.
- R11: The direct byte port (op 5) reads or writes byte 12+accSel[1:0] of data register 0, returned in rdata[7:0], without rotating anything.
- R12: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowPower | input | 1 | Low-power entry: clear all but the key buffer |
| wideKey | input | 1 | 1: key registers 256 bits on their own, 0: 128 bits |
| accEn | input | 1 | Access strobe, one word or byte per cycle |
| accWrite | input | 1 | 1 write, 0 read |
| accOp | input | 3 | 0 word, 1 XOR word, 2 byte reg0, 3 XOR byte reg0, 4 byte reg1, 5 direct byte |
| accSel | input | 4 | View number for op 0, byte number for op 5 |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Read data for the current access (combinational) |

## Verification
The bench builds the bank with the default 32-bit word and 128-bit base register. These are the only sizes for which the byte grouping and the 4/8/16-word transfer counts apply. The defaults make every view reachable within a few hundred cycles, including both key widths, the wrap of the 512-bit views and the byte-reversed aliases. A behavioural word-array model predicts every read, so partial rotations, cross-view aliasing and low-power retention are each checked word by word.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  typedef enum logic [3:0] {
    V_D0 = 4'd0, V_D1 = 4'd1, V_D2 = 4'd2, V_D3 = 4'd3,
    V_KEY = 4'd4, V_KBUF = 4'd5,
    V_PAIR0 = 4'd6, V_PAIR1 = 4'd7,
    V_QUAD0 = 4'd8, V_QUAD1 = 4'd9,
    V_SPAIR0 = 4'd10, V_SQUAD1 = 4'd11,
    V_NONE = 4'd15
  } view_e;

  typedef enum logic [2:0] {
    OP_WORD = 3'd0, OP_XOR = 3'd1, OP_BYTE0 = 3'd2,
    OP_XBYTE0 = 3'd3, OP_BYTE1 = 3'd4, OP_DIRECT = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0, RD_VIEW = 2'd1, RD_BYTE = 2'd2, RD_DIRECT = 2'd3
  } rdsrc_e;

  typedef struct packed {
    logic       clear;
    logic       shift;
    logic       wr;
    logic       xorIn;
    logic       byteMode;
    logic       wideKey;
    view_e      view;
    logic       bufPut;
    logic       bufLoad;
    logic       dirWr;
    logic [1:0] dirIdx;
    logic [1:0] byteIdx;
    rdsrc_e     rdSrc;
  } wrb_ctl_t;

endpackage

// File: rtl/wrb_ctrl.sv
module wrb_ctrl
  import wrb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowPower,
  input  logic       wideKey,
  input  logic       accEn,
  input  logic       accWrite,
  input  logic [2:0] accOp,
  input  logic [3:0] accSel,
  output wrb_ctl_t   ctl
);

  logic [1:0] byteCnt;
  logic       byteOp;
  logic       selValid;

  assign byteOp   = accEn && (accOp == OP_BYTE0 || accOp == OP_XBYTE0 || accOp == OP_BYTE1);
  assign selValid = (accSel <= 4'd11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         byteCnt <= '0;
    else if (lowPower) byteCnt <= '0;
    else if (byteOp)   byteCnt <= byteCnt + 2'd1;
  end

  always_comb begin
    ctl          = '0;
    ctl.view     = V_NONE;
    ctl.rdSrc    = RD_NONE;
    ctl.wideKey  = wideKey;
    ctl.byteIdx  = byteCnt;
    ctl.wr       = accWrite;
    ctl.dirIdx   = accSel[1:0];
    case (op_e'(accOp))
      OP_WORD: begin
        ctl.view  = selValid ? view_e'(accSel) : V_NONE;
        ctl.shift = accEn && selValid;
        ctl.rdSrc = selValid ? RD_VIEW : RD_NONE;
      end
      OP_XOR: begin
        ctl.view  = V_D0;
        ctl.xorIn = 1'b1;
        ctl.shift = accEn;
        ctl.rdSrc = RD_VIEW;
      end
      OP_BYTE0, OP_XBYTE0, OP_BYTE1: begin
        ctl.view     = (accOp == OP_BYTE1) ? V_D1 : V_D0;
        ctl.xorIn    = (accOp == OP_XBYTE0);
        ctl.byteMode = 1'b1;
        ctl.rdSrc    = RD_BYTE;
        ctl.shift    = accEn && (accWrite ? (byteCnt == 2'd3) : (byteCnt == 2'd0));
        ctl.bufPut   = accEn && accWrite && (byteCnt != 2'd3);
        ctl.bufLoad  = accEn && !accWrite && (byteCnt == 2'd0);
      end
      OP_DIRECT: begin
        ctl.dirWr = accEn && accWrite;
        ctl.rdSrc = RD_DIRECT;
      end
      default: ;
    endcase
    if (lowPower) begin
      ctl.clear   = 1'b1;
      ctl.shift   = 1'b0;
      ctl.bufPut  = 1'b0;
      ctl.bufLoad = 1'b0;
      ctl.dirWr   = 1'b0;
    end
  end

endmodule

// File: rtl/wrb_datapath.sv
module wrb_datapath
  import wrb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BASE_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrb_ctl_t          ctl,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int BASE_WORDS = BASE_W / WORD_W;
  localparam int KEY_W      = 2 * BASE_W;
  localparam int VIEW_W     = 4 * BASE_W;
  localparam int VIEW_WORDS = VIEW_W / WORD_W;
  localparam int NBYTES     = WORD_W / 8;

  logic [BASE_W-1:0] dReg [4];
  logic [KEY_W-1:0]  keyReg;
  logic [KEY_W-1:0]  kbReg;
  logic [WORD_W-1:0] byteBuf;

  logic [VIEW_W-1:0] viewVec, nextVec, storeVec;
  logic [WORD_W-1:0] lowWord, inWord, newTop;
  logic              swapV;
  int                nWords;

  function automatic logic [WORD_W-1:0] bswap(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < NBYTES; b++) r[8*b +: 8] = w[8*(NBYTES-1-b) +: 8];
    return r;
  endfunction

  function automatic logic [VIEW_W-1:0] swapAll(input logic [VIEW_W-1:0] v);
    logic [VIEW_W-1:0] r;
    for (int i = 0; i < VIEW_WORDS; i++) r[i*WORD_W +: WORD_W] = bswap(v[i*WORD_W +: WORD_W]);
    return r;
  endfunction

  // gather the selected view into a common vector
  always_comb begin
    viewVec = '0;
    nWords  = 0;
    swapV   = 1'b0;
    case (ctl.view)
      V_D0:   begin viewVec[BASE_W-1:0] = dReg[0]; nWords = BASE_WORDS; end
      V_D1:   begin viewVec[BASE_W-1:0] = dReg[1]; nWords = BASE_WORDS; end
      V_D2:   begin viewVec[BASE_W-1:0] = dReg[2]; nWords = BASE_WORDS; end
      V_D3:   begin viewVec[BASE_W-1:0] = dReg[3]; nWords = BASE_WORDS; end
      V_KEY:  begin viewVec[KEY_W-1:0] = keyReg; nWords = ctl.wideKey ? 2*BASE_WORDS : BASE_WORDS; end
      V_KBUF: begin viewVec[KEY_W-1:0] = kbReg;  nWords = ctl.wideKey ? 2*BASE_WORDS : BASE_WORDS; end
      V_PAIR0, V_SPAIR0: begin
        viewVec[KEY_W-1:0] = {dReg[1], dReg[0]};
        nWords = 2*BASE_WORDS;
        swapV  = (ctl.view == V_SPAIR0);
      end
      V_PAIR1: begin viewVec[KEY_W-1:0] = {dReg[3], dReg[2]}; nWords = 2*BASE_WORDS; end
      V_QUAD0: begin viewVec = {dReg[3], dReg[2], dReg[1], dReg[0]}; nWords = VIEW_WORDS; end
      V_QUAD1, V_SQUAD1: begin
        viewVec = {kbReg, keyReg};
        nWords  = VIEW_WORDS;
        swapV   = (ctl.view == V_SQUAD1);
      end
      default: ;
    endcase
    if (swapV) viewVec = swapAll(viewVec);
  end

  // one-word rotation with the new top word
  always_comb begin
    lowWord = viewVec[WORD_W-1:0];
    inWord  = ctl.byteMode ? {wdata[7:0], byteBuf[WORD_W-9:0]} : wdata;
    newTop  = ctl.wr ? (ctl.xorIn ? (inWord ^ lowWord) : inWord) : lowWord;
    nextVec = viewVec >> WORD_W;
    for (int i = 0; i < VIEW_WORDS; i++)
      if (i == nWords - 1) nextVec[i*WORD_W +: WORD_W] = newTop;
    storeVec = swapV ? swapAll(nextVec) : nextVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < 4; r++) dReg[r] <= '0;
      keyReg  <= '0;
      kbReg   <= '0;
      byteBuf <= '0;
    end else if (ctl.clear) begin
      for (int r = 0; r < 4; r++) dReg[r] <= '0;
      keyReg  <= '0;
      byteBuf <= '0;
    end else begin
      if (ctl.shift) begin
        case (ctl.view)
          V_D0: dReg[0] <= storeVec[BASE_W-1:0];
          V_D1: dReg[1] <= storeVec[BASE_W-1:0];
          V_D2: dReg[2] <= storeVec[BASE_W-1:0];
          V_D3: dReg[3] <= storeVec[BASE_W-1:0];
          V_KEY: begin
            if (ctl.wideKey) keyReg <= storeVec[KEY_W-1:0];
            else             keyReg[BASE_W-1:0] <= storeVec[BASE_W-1:0];
          end
          V_KBUF: begin
            if (ctl.wideKey) kbReg <= storeVec[KEY_W-1:0];
            else             kbReg[BASE_W-1:0] <= storeVec[BASE_W-1:0];
          end
          V_PAIR0, V_SPAIR0: {dReg[1], dReg[0]} <= storeVec[KEY_W-1:0];
          V_PAIR1: {dReg[3], dReg[2]} <= storeVec[KEY_W-1:0];
          V_QUAD0: {dReg[3], dReg[2], dReg[1], dReg[0]} <= storeVec;
          V_QUAD1, V_SQUAD1: {kbReg, keyReg} <= storeVec;
          default: ;
        endcase
      end
      if (ctl.bufPut)  byteBuf[8*int'(ctl.byteIdx) +: 8] <= wdata[7:0];
      if (ctl.bufLoad) byteBuf <= lowWord;
      if (ctl.dirWr)   dReg[0][(BASE_W-WORD_W) + 8*int'(ctl.dirIdx) +: 8] <= wdata[7:0];
    end
  end

  always_comb begin
    case (ctl.rdSrc)
      RD_VIEW:   rdata = lowWord;
      RD_BYTE:   rdata = {{(WORD_W-8){1'b0}},
                          (ctl.byteIdx == 2'd0) ? lowWord[7:0] : byteBuf[8*int'(ctl.byteIdx) +: 8]};
      RD_DIRECT: rdata = {{(WORD_W-8){1'b0}}, dReg[0][(BASE_W-WORD_W) + 8*int'(ctl.dirIdx) +: 8]};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/wide_reg_bank.sv
module wide_reg_bank
  import wrb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BASE_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPower,
  input  logic              wideKey,
  input  logic              accEn,
  input  logic              accWrite,
  input  logic [2:0]        accOp,
  input  logic [3:0]        accSel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  wrb_ctl_t ctlBus;

  wrb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .wideKey(wideKey),
    .accEn(accEn), .accWrite(accWrite), .accOp(accOp), .accSel(accSel),
    .ctl(ctlBus)
  );

  wrb_datapath #(.WORD_W(WORD_W), .BASE_W(BASE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .wdata(wdata), .rdata(rdata)
  );

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        lowPower,
  input logic        accEn,
  input logic        accWrite,
  input logic [2:0]  accOp,
  input logic [3:0]  accSel,
  input logic [31:0] rdataLow,
  input logic [1:0]  byteIdx,
  input logic        shift,
  input logic        bufPut,
  input logic        bufLoad,
  input logic        dirWr
);

  logic byteAcc;
  logic directRd;
  assign byteAcc  = accEn && !lowPower && (accOp == 3'd2 || accOp == 3'd3 || accOp == 3'd4);
  assign directRd = accEn && !lowPower && !accWrite && (accOp == 3'd5);

  // R10
  sleep_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |=> (byteIdx == 2'd0));

  // R5
  byte_count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteAcc |=> (byteIdx == $past(byteIdx) + 2'd1));

  // R5
  word_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !lowPower && (accOp == 3'd0 || accOp == 3'd1 || accOp == 3'd5)) |=> $stable(byteIdx));

  // R5
  group_end_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteAcc && accWrite && byteIdx == 2'd3) |-> shift);

  // R11
  direct_no_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (directRd && $past(directRd) && $stable(accSel)) |-> $stable(rdataLow));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bufPut, bufLoad, dirWr}));

endmodule

bind wide_reg_bank wrb_checker chk_i (
  .clk(clk), .rstN(rstN), .lowPower(lowPower), .accEn(accEn), .accWrite(accWrite),
  .accOp(accOp), .accSel(accSel), .rdataLow(rdata[31:0]), .byteIdx(ctlBus.byteIdx),
  .shift(ctlBus.shift), .bufPut(ctlBus.bufPut), .bufLoad(ctlBus.bufLoad), .dirWr(ctlBus.dirWr)
);

// File: tb/wide_reg_bank_tb_top.sv
`timescale 1ns/100ps
module wide_reg_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lowPower = 1'b0;
  logic        wideKey = 1'b0;
  logic        accEn = 1'b0;
  logic        accWrite = 1'b0;
  logic [2:0]  accOp = 3'd0;
  logic [3:0]  accSel = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  // model: words 0..15 data regs, 16..23 key, 24..31 key buffer
  logic [31:0] m [0:31];
  logic [31:0] mbuf = 32'd0;
  int          mcnt = 0;

  always #2.5 clk = ~clk;

  wide_reg_bank dut_i (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .wideKey(wideKey),
    .accEn(accEn), .accWrite(accWrite), .accOp(accOp), .accSel(accSel),
    .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] bs(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // view -> list of model word indices, LSW first
  function automatic int vlen(input int v);
    case (v)
      0, 1, 2, 3: return 4;
      4, 5:       return wideKey ? 8 : 4;
      6, 7, 10:   return 8;
      8, 9, 11:   return 16;
      default:    return 0;
    endcase
  endfunction

  function automatic int vbase(input int v);
    case (v)
      0, 1, 2, 3: return 4 * v;
      4, 9, 11:   return 16;
      5:          return 24;
      7:          return 8;
      default:    return 0;
    endcase
  endfunction

  // one rotation step in the model; returns the view's low word before the step
  function automatic logic [31:0] mstep(input int v, input bit wr, input bit xr, input logic [31:0] d);
    int n = vlen(v);
    int b = vbase(v);
    bit sw = (v == 10 || v == 11);
    logic [31:0] low, top;
    if (n == 0) return 32'd0;
    low = sw ? bs(m[b]) : m[b];
    top = wr ? (xr ? (d ^ low) : d) : low;
    for (int j = 0; j < n - 1; j++) m[b+j] = m[b+j+1];
    m[b+n-1] = sw ? bs(top) : top;
    return low;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input int op, input int sel, input bit wr, input logic [31:0] d, input string tag);
    logic [31:0] exp = 32'd0;
    int v = (op == 0) ? sel : ((op == 4) ? 1 : 0);
    case (op)
      0, 1: exp = mstep(v, wr, op == 1, d);
      2, 3, 4: begin
        if (wr) begin
          if (mcnt == 3) void'(mstep(v, 1'b1, op == 3, {d[7:0], mbuf[23:0]}));
          else mbuf[8*mcnt +: 8] = d[7:0];
        end else if (mcnt == 0) begin
          mbuf = mstep(v, 1'b0, 1'b0, 32'd0);
          exp = {24'd0, mbuf[7:0]};
        end else exp = {24'd0, mbuf[8*mcnt +: 8]};
        mcnt = (mcnt + 1) % 4;
      end
      5: begin
        if (wr) m[3][8*(sel%4) +: 8] = d[7:0];
        exp = {24'd0, m[3][8*(sel%4) +: 8]};
      end
      default: ;
    endcase
    @(negedge clk);
    accEn = 1'b1; accWrite = wr; accOp = 3'(op); accSel = 4'(sel); wdata = d;
    #1;
    if (!wr) check(tag, rdata, exp);
    @(posedge clk);
    #0.5 accEn = 1'b0;
  endtask

  task automatic sleep();
    for (int i = 0; i < 24; i++) m[i] = 32'd0;
    mbuf = 32'd0; mcnt = 0;
    @(negedge clk); lowPower = 1'b1;
    accEn = 1'b1; accWrite = 1'b1; accOp = 3'd0; accSel = 4'd5; wdata = 32'hDEAD_BEEF;
    @(posedge clk);
    #0.5 lowPower = 1'b0; accEn = 1'b0;
  endtask

  task automatic rdView(input int v, input int k, input string tag);
    for (int i = 0; i < k; i++) acc(0, v, 1'b0, 32'd0, tag);
  endtask

  task automatic wrView(input int v, input int k, input logic [31:0] seed, input string tag);
    for (int i = 0; i < k; i++) acc(0, v, 1'b1, seed + 32'(i) * 32'h0102_0305, tag);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 32'd0;
    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;
    // R12 reset state
    rdView(0, 4, "R12"); rdView(3, 4, "R12"); wideKey = 1'b1; rdView(5, 8, "R12");
    // R2 / R1 round trip on a 128-bit register
    wrView(0, 4, 32'hA000_0001, "R2"); rdView(0, 4, "R1"); rdView(0, 4, "R1");
    // R8 pair alias
    wrView(6, 8, 32'h1111_0000, "R8"); rdView(1, 4, "R8"); rdView(0, 4, "R8"); rdView(6, 8, "R1");
    // R8 512-bit view over all data registers
    wrView(8, 16, 32'h5A00_0010, "R8"); rdView(3, 4, "R8"); rdView(8, 16, "R1"); rdView(7, 8, "R8");
    // R3 partial read then full read
    rdView(2, 2, "R3"); rdView(2, 4, "R3"); rdView(8, 5, "R3"); rdView(8, 16, "R3");
    // R4 xor accumulate, twice
    for (int i = 0; i < 4; i++) acc(1, 0, 1'b1, 32'hF0F0_0000 + 32'(i), "R4");
    rdView(0, 4, "R4");
    for (int i = 0; i < 4; i++) acc(1, 0, 1'b1, 32'h0FF0_1234 * 32'(i + 1), "R4");
    acc(1, 0, 1'b0, 32'd0, "R4"); rdView(0, 3, "R4");
    // R5 byte writes to reg1 and xor bytes to reg0
    for (int i = 0; i < 8; i++) acc(4, 0, 1'b1, 32'(8'h30 + i), "R5");
    rdView(1, 4, "R5");
    for (int i = 0; i < 4; i++) acc(3, 0, 1'b1, 32'(8'hC1 + 3 * i), "R5");
    rdView(0, 4, "R5");
    for (int i = 0; i < 4; i++) acc(2, 0, 1'b1, 32'(8'h71 + i), "R5");
    rdView(0, 4, "R5");
    // R6 byte reads
    for (int i = 0; i < 8; i++) acc(2, 0, 1'b0, 32'd0, "R6");
    rdView(0, 4, "R6");
    for (int i = 0; i < 4; i++) acc(4, 0, 1'b0, 32'd0, "R6");
    rdView(1, 4, "R6");
    // R7 key widths
    wideKey = 1'b1; wrView(4, 8, 32'h0C0C_0000, "R7");
    wideKey = 1'b0; wrView(4, 4, 32'h7E57_0000, "R7"); rdView(4, 4, "R7");
    wideKey = 1'b1; rdView(4, 8, "R7"); wrView(5, 8, 32'hB0F0_0100, "R7");
    wideKey = 1'b0; rdView(9, 16, "R7"); wrView(9, 16, 32'h9900_0001, "R8");
    wideKey = 1'b1; rdView(5, 8, "R8"); rdView(4, 8, "R8");
    // R9 byte-reversed views
    wrView(10, 8, 32'h0102_0304, "R9"); rdView(0, 4, "R9"); rdView(10, 8, "R9");
    rdView(11, 16, "R9"); wrView(11, 16, 32'hAABB_CC00, "R9"); rdView(9, 16, "R9");
    // R11 direct byte access to bytes 12..15 of reg0
    for (int i = 0; i < 4; i++) acc(5, i, 1'b1, 32'(8'hE0 + i), "R11");
    for (int i = 0; i < 4; i++) acc(5, i, 1'b0, 32'd0, "R11");
    acc(5, 2, 1'b0, 32'd0, "R11"); acc(5, 2, 1'b0, 32'd0, "R11");
    rdView(0, 4, "R11");
    // R10 low-power clear, key buffer kept, byte counter cleared
    wrView(8, 16, 32'h3300_0007, "R10");
    for (int i = 0; i < 2; i++) acc(4, 0, 1'b1, 32'(8'h55 + i), "R10");
    sleep();
    rdView(8, 16, "R10"); rdView(4, 8, "R10"); rdView(5, 8, "R10");
    for (int i = 0; i < 4; i++) acc(4, 0, 1'b1, 32'(8'h91 + i), "R5");
    rdView(1, 4, "R10");
    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule